// File: doc/BRIEF.md
# Serial EEPROM-Protocol I2C Slave Controller

This block is the slave side of a two-wire serial memory. It brings the bus clock and data lines through a short synchroniser and finds START and STOP conditions on the synchronised copies. After a START it takes a device-select byte, two pointer bytes and any number of data bytes. It answers current-pointer reads, pointer-then-read (random) reads and streaming reads that run over the whole array. Its only output is an open-drain pull-down enable for the data line. Each received data byte becomes a one-cycle write request to a storage module, which is a plain synchronous RAM model holding `2**ADDR_W` bytes. A full 8192-byte part uses `ADDR_W = 13`. The default is smaller to keep elaboration light.

A STOP that closes a write holding at least one data byte starts an emulated programming interval of `WR_CYCLES` system clocks. During that interval every device-select byte is left unanswered, so the master can poll until the part responds again. The system clock must run at least 16 times faster than the bus clock.

The FSM has these states. `ST_IDLE` ignores the bus. `ST_DEVADR` receives the device-select byte. `ST_ADRHI` and `ST_ADRLO` receive the pointer bytes. `ST_WDATA` receives data. `ST_ACK` is the slave's acknowledge slot. `ST_RDATA` shifts out a byte. `ST_MACK` samples the master's acknowledge.

A START from any state goes to `ST_DEVADR`. A STOP from any state goes to `ST_IDLE`. From `ST_DEVADR`, a match goes to `ST_ACK` and a mismatch or busy goes to `ST_IDLE`. `ST_ADRHI`, `ST_ADRLO` and `ST_WDATA` each go to `ST_ACK` after 8 bits. `ST_ACK` goes to `ST_ADRHI`, `ST_ADRLO`, `ST_WDATA` or `ST_RDATA` on its second falling edge. `ST_RDATA` goes to `ST_MACK` after 8 bits. `ST_MACK` goes to `ST_RDATA` on a master ACK and to `ST_IDLE` on a NACK.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), the pointer is 0 and the slave is idle.
- R2: A device-select byte is accepted (ACK) only when bits 7..4 are 1010 and bits 3..1 equal `dev_sel`. Bit 0 is 1 for read and 0 for write. A mismatching byte is NACKed, and all later bytes are ignored until the next START.
- R3: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Bytes clocked before any START get no ACK.
- R4: Bits are MSB first and sampled on the rising edge of SCL. `sda_oe` changes only while SCL is low.
- R5: The slave acknowledges by pulling SDA low during the ninth clock. It does so for a matching device-select byte, both pointer bytes and every write data byte.
- R6: In a write, the pointer becomes the low `ADDR_W` bits of {high byte, low byte}, and higher bits are don't-care. Each data byte is stored at the pointer and then the pointer increments, so successive data bytes land at consecutive addresses.
- R7: A random read is a write-mode select plus two pointer bytes, then a repeated START and a read-mode select. It returns the byte at the loaded pointer.
- R8: A read-mode select right after START returns the byte at the current pointer. After any read or write the pointer is the address of the last byte accessed plus one.
- R9: A master ACK after a read byte makes the slave send the next byte, wrapping from `2**ADDR_W-1` to 0. A master NACK releases the line, and the slave drives nothing until the next START.
- R10: After a STOP that ends a write with at least one data byte, device-select bytes are NACKed for `WR_CYCLES` clocks and then ACKed again. No write request is issued in that window.
- R11: A START in the middle of a byte abandons it: the partial byte is not stored and address reception restarts.
- R12: A STOP after the pointer bytes but before any data byte leaves memory unchanged and starts no busy interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_sel | input | 3 | Strap value matched against select bits 3..1 |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong pointer shows on the very next read byte, since every returned value is checked against an arithmetic pattern written over the whole array. A wrong bit or phase counter shows within one byte, as a missing or misplaced ACK, a bit shifted in the returned data, or a line driven when it should be released. A wrong busy timer shows on the first or second poll after a write STOP, because the bench computes the exact poll on which the first ACK must arrive.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_ADRHI,
        ST_ADRLO,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK
    } ee_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_eeprom_mem.sv
module i2c_eeprom_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
    parameter int WR_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (go) begin
            remain <= CW'(WR_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int WR_CYCLES   = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel,
    output logic       sda_oe
);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, cyc_go, got_data, ack_phase, m_ack;
    logic mem_we;
    logic [ADDR_W-1:0] mem_wa, ptr;
    logic [7:0] mem_wd, rd_q, shreg, hi_q, tx, rx_byte;
    logic [2:0] bitcnt;
    ee_state_t state, next_st;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_eeprom_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) mem_i (
        .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
        .raddr(ptr), .rdata(rd_q)
    );

    i2c_wr_timer #(.WR_CYCLES(WR_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .go(cyc_go), .busy(busy)
    );

    assign rx_byte = {shreg[6:0], sda_s};

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            next_st   <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            hi_q      <= '0;
            tx        <= '0;
            ptr       <= '0;
            ack_phase <= 1'b0;
            m_ack     <= 1'b0;
            got_data  <= 1'b0;
            cyc_go    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wa    <= '0;
            mem_wd    <= '0;
        end else begin
            mem_we <= 1'b0;
            cyc_go <= 1'b0;
            if (start_det) begin
                state     <= ST_DEVADR;
                bitcnt    <= '0;
                ack_phase <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                cyc_go   <= got_data;
                got_data <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_DEVADR, ST_ADRHI, ST_ADRLO, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                state <= ST_ACK;
                                if (state == ST_DEVADR) begin
                                    if (rx_byte[7:4] == DEV_TYPE && rx_byte[3:1] == dev_sel && !busy) begin
                                        next_st <= rx_byte[0] ? ST_RDATA : ST_ADRHI;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else if (state == ST_ADRHI) begin
                                    hi_q    <= rx_byte;
                                    next_st <= ST_ADRLO;
                                end else if (state == ST_ADRLO) begin
                                    ptr     <= ADDR_W'({hi_q, rx_byte});
                                    next_st <= ST_WDATA;
                                end else begin
                                    mem_we   <= 1'b1;
                                    mem_wa   <= ptr;
                                    mem_wd   <= rx_byte;
                                    ptr      <= ptr + PTR_ONE;
                                    got_data <= 1'b1;
                                    next_st  <= ST_WDATA;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_phase) begin
                                ack_phase <= 1'b1;
                            end else begin
                                ack_phase <= 1'b0;
                                state     <= next_st;
                                bitcnt    <= '0;
                                if (next_st == ST_RDATA) begin
                                    tx  <= rd_q;
                                    ptr <= ptr + PTR_ONE;
                                end
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                state  <= ST_MACK;
                                bitcnt <= '0;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end
                        if (scl_fall) begin
                            if (m_ack) begin
                                state  <= ST_RDATA;
                                tx     <= rd_q;
                                ptr    <= ptr + PTR_ONE;
                                bitcnt <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_ACK:   sda_oe = ack_phase;
            ST_RDATA: sda_oe = ~tx[7];
            default:  sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk
    import i2c_eeprom_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sda_oe,
    input logic      scl_s,
    input logic      start_det,
    input logic      stop_det,
    input logic      busy,
    input logic      mem_we,
    input ee_state_t state
);

    // R4: the pull-down enable moves only while the synchronised clock is low
    assert_oe_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

    // R10: no acknowledge and no drive during the programming interval
    assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R10: no write request while the programming interval runs
    assert_busy_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy);

    // R11: a START always restarts device-select reception
    assert_start_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEVADR));

endmodule

bind i2c_eeprom_slave i2c_eeprom_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .busy(busy),
    .mem_we(mem_we), .state(state)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;
    localparam int AW    = 7;
    localparam int DEPTH = 1 << AW;
    localparam int WRC   = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [2:0] strap = 3'b101;
    logic sda_line;
    int total = 0;
    int bad = 0;
    int viol = 0;
    logic prev_oe = 1'b0;

    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_eeprom_slave #(.ADDR_W(AW), .WR_CYCLES(WRC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_sel(strap), .sda_oe(sda_oe)
    );

    // R4 monitor: the enable must not move while the bench holds SCL high
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
        prev_oe <= sda_oe;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        if (scl_m) begin
            wt(6); sda_m = 1'b0; wt(6); scl_m = 1'b0;
        end else begin
            wt(6); sda_m = 1'b1; wt(6); scl_m = 1'b1;
            wt(6); sda_m = 1'b0; wt(6); scl_m = 1'b0;
        end
    endtask

    task automatic bus_stop();
        wt(6); sda_m = 1'b0; wt(6); scl_m = 1'b1; wt(6); sda_m = 1'b1; wt(6);
    endtask

    task automatic clk_bit(input logic drv, output logic smp);
        wt(6); sda_m = drv; wt(6); scl_m = 1'b1; wt(6); smp = sda_line; wt(6); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack); chk(ack, req, ack, 1);
        send_byte(hi, ack);    chk(ack, req, ack, 1);
        send_byte(lo, ack);    chk(ack, req, ack, 1);
    endtask

    task automatic poll_ready(output int n);
        logic ack;
        n = 0;
        for (int k = 0; k < 6; k++) begin
            bus_start();
            send_byte(DEV_W, ack);
            bus_stop();
            n++;
            if (k == 0) chk(!ack, "R10 first poll after write must be NACKed", ack, 0);
            if (ack) break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        int n;
        wt(10); rst_n = 1'b1; wt(10);
        chk(sda_oe == 1'b0 && sda_line == 1'b1, "R1 released after reset", sda_oe, 0);

        // R3: no START yet, byte must be ignored
        scl_m = 1'b0; wt(6);
        send_byte(DEV_W, ack);
        chk(!ack, "R3 byte before START", ack, 0);

        // R2: wrong strap, then ignored until START, then wrong type
        bus_start();
        send_byte(8'hA8, ack); chk(!ack, "R2 wrong strap", ack, 0);
        send_byte(DEV_W, ack); chk(!ack, "R2 ignored until START", ack, 0);
        bus_start();
        send_byte(8'hBA, ack); chk(!ack, "R2 wrong type nibble", ack, 0);
        bus_stop();

        // R5/R6: fill whole array from pointer 0 (high bits don't-care)
        set_ptr(8'hFF, 8'h80, "R5 ack on select and pointer bytes");
        for (int a = 0; a < DEPTH; a++) begin
            send_byte(pat(a), ack);
            chk(ack, "R5 ack on data byte", ack, 1);
        end
        bus_stop();

        // R10: busy polling; first ACK on poll 2 for WRC=300
        poll_ready(n);
        chk(n == 2, "R10 polls until ACK", n, 2);

        // R12: previous poll was a write with no data: no busy
        bus_start();
        send_byte(DEV_W, ack); chk(ack, "R12 no busy after data-less write", ack, 1);
        bus_stop();

        // R8/R9/R6: current-pointer read streaming past the wrap
        bus_start();
        send_byte(DEV_R, ack); chk(ack, "R8 read select ACK", ack, 1);
        for (int i = 0; i < DEPTH + 2; i++) begin
            recv_byte(i != DEPTH + 1, b);
            chk(b == pat(i % DEPTH), "R9 sequential read with wrap", b, pat(i % DEPTH));
        end
        // R9: after NACK nothing is driven until a START
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R9 released after NACK", b, 8'hFF);
        bus_stop();

        // R8: pointer = last read + 1 = 2
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        chk(b == pat(2), "R8 pointer after sequential read", b, pat(2));
        bus_stop();

        // R7: random read
        set_ptr(8'hC3, 8'h45, "R7 pointer load");
        bus_start();
        send_byte(DEV_R, ack); chk(ack, "R7 read select after repeated START", ack, 1);
        recv_byte(1'b0, b);
        chk(b == pat(8'h45), "R7 random read", b, pat(8'h45));
        bus_stop();
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        chk(b == pat(8'h46), "R8 pointer after random read", b, pat(8'h46));
        bus_stop();

        // R6: single byte write, neighbours untouched
        set_ptr(8'h7F, 8'h10, "R6 pointer load");
        send_byte(8'h5A, ack); chk(ack, "R6 data ACK", ack, 1);
        bus_stop();
        poll_ready(n);
        set_ptr(8'h00, 8'h10, "R6 readback pointer");
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b1, b); chk(b == 8'h5A, "R6 written byte", b, 8'h5A);
        recv_byte(1'b0, b); chk(b == pat(8'h11), "R6 next byte unchanged", b, pat(8'h11));
        bus_stop();

        // R11: START in mid-byte abandons the partial data byte
        set_ptr(8'hFF, 8'h20, "R11 pointer load");
        clk_bit(1'b0, ack); clk_bit(1'b1, ack); clk_bit(1'b0, ack); clk_bit(1'b1, ack);
        bus_start();
        send_byte(DEV_R, ack); chk(ack, "R11 select after mid-byte START", ack, 1);
        recv_byte(1'b0, b);
        chk(b == pat(8'h20), "R11 partial byte not stored", b, pat(8'h20));
        bus_stop();

        // R12: STOP after pointer bytes, before data
        set_ptr(8'hFF, 8'h30, "R12 pointer load");
        bus_stop();
        set_ptr(8'h00, 8'h30, "R12 immediate ACK, no busy");
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        chk(b == pat(8'h30), "R12 memory unchanged", b, pat(8'h30));
        bus_stop();

        chk(viol == 0, "R4 sda_oe moved while SCL high", viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule